// File: doc/BRIEF.md
# RTC Periodic Interrupt and Pulse Generator

This block produces the periodic events of a real-time-clock peripheral. A 32.768 kHz timebase arrives as a one-cycle enable (`tick_en`) in the system clock domain. A 4-bit rate code selects a period that is a power of two of timebase ticks. At each period boundary the block can set two status flags and raise a level interrupt, emit a one-cycle event pulse, or do both. Each of these two paths has its own enable bit.

Software reaches three byte registers through a small read/write port. The rate register holds the rate code in its low nibble. The control register holds the two enable bits. The status register holds the flags, and reading it clears them. The interrupt output follows the main flag. The event pulse stands in for a square-wave output: it gives one short pulse per period instead of a 50% duty waveform, and it never touches the status flags.

Top module: `rtc_periodic_gen`

## Requirements
- R1: After reset, the rate register (address 0) reads 0x26, the control register (address 1) reads 0x02 and the status register (address 2) reads 0x00. `irq_o` and `evt_pulse_o` are low.
- R2: Addresses 0 and 1 are 8-bit read/write registers. Address 2 is read-only, and a write to it has no effect. Address 3 reads 0x00. `reg_rdata` shows the addressed register in the same cycle, with no clock delay.
- R3: For an effective rate code n from 3 to 15, events occur every 2^(n-1) ticks of `tick_en`. Rate codes 1 and 2 act as codes 8 and 9 (128 and 256 ticks). The first event after a restart comes exactly one period after it.
- R4: A rate code of 0 (rate register bits 3:0) produces no events at all.
- R5: The period counter runs only while control bit 6 or control bit 3 is set. Otherwise it is held at zero, so enabling either bit starts a full period.
- R6: At a boundary with control bit 6 set, status bits 7 and 6 are set on the clock edge that takes the final tick. `irq_o` equals status bit 7 and stays high until the status register is read.
- R7: At a boundary with control bit 3 set, `evt_pulse_o` is high for exactly one clock cycle, starting after the edge that takes the final tick. Status flags are unaffected.
- R8: A read of address 2 (`reg_rd` high) returns the current flags and clears status bits 7 and 6 on that clock edge. `irq_o` drops in the following cycle.
- R9: When a status read and a boundary with control bit 6 set fall on the same edge, the read returns the old value and the flags end up set.
- R10: A write to the rate register restarts the period counter from zero with the new code. A tick on the write edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz timebase tick |
| reg_addr | input | 2 | Register select: 0 rate, 1 control, 2 status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of the status register clears its flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Level interrupt request, equal to status bit 7 |
| evt_pulse_o | output | 1 | One-cycle pulse per period when control bit 3 is set |

## Verification
Two functions can act on the status flags in the same cycle: the read-to-clear of the status register and a period boundary that sets them. The bench runs the fastest rate with a tick on every cycle. With flags already set from the previous event, it issues a status read exactly one cycle before the next boundary edge. The collision is judged on two points: the read data must show the old flags, and `irq_o` must still be high after that edge. A second read, made away from any boundary, must then clear `irq_o`.

// File: rtl/rtc_periodic_pkg.sv
package rtc_periodic_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int RATE_W = 4;
    // longest period is 2^(2^RATE_W - 2) ticks
    localparam int CNT_W  = (1 << RATE_W) - 2;

    localparam logic [ADDR_W-1:0] ADR_RATE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(2);

    localparam logic [DATA_W-1:0] RATE_RST = 8'h26;
    localparam logic [DATA_W-1:0] CTRL_RST = 8'h02;

    localparam int CTRL_INTR_BIT  = 6;
    localparam int CTRL_PULSE_BIT = 3;
    localparam int STAT_IRQ_BIT   = 7;
    localparam int STAT_PER_BIT   = 6;

    // low codes are remapped to slower rates
    localparam int ALIAS_MAX = 2;
    localparam int ALIAS_OFS = 7;

    typedef struct packed {
        logic [DATA_W-1:0] rate;
        logic [DATA_W-1:0] ctrl;
        logic [1:0]        flags;  // [1] interrupt flag, [0] periodic flag
        logic              pulse;
    } regs_t;
endpackage

// File: rtl/rtc_rate_decode.sv
module rtc_rate_decode
    import rtc_periodic_pkg::*;
(
    input  logic [RATE_W-1:0] code_i,
    output logic              active_o,
    output logic [CNT_W-1:0]  term_o
);
    logic [RATE_W-1:0] eff;
    logic [CNT_W:0]    span;

    always_comb begin
        eff = code_i;
        if (code_i != '0 && code_i <= RATE_W'(ALIAS_MAX))
            eff = code_i + RATE_W'(ALIAS_OFS);
        active_o = (code_i != '0);
        span = '0;
        for (int i = 1; i < (1 << RATE_W); i++) begin
            if (eff == RATE_W'(i))
                span = (CNT_W+1)'(1) << (i - 1);
        end
        // terminal count is one less than the period length
        term_o = CNT_W'(span - 1'b1);
    end
endmodule

// File: rtl/rtc_period_counter.sv
module rtc_period_counter
    import rtc_periodic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             boundary_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        boundary_o = run_i && !restart_i && tick_i && (cnt_q == term_i);
        cnt_d = cnt_q;
        if (restart_i || !run_i)
            cnt_d = '0;
        else if (boundary_o)
            cnt_d = '0;
        else if (tick_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
    import rtc_periodic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              evt_pulse_o
);
    regs_t             r_d, r_q;
    logic              rate_active;
    logic [CNT_W-1:0]  rate_term;
    logic              run, restart, boundary, rd_stat, wr_ctrl;
    logic [RATE_W-1:0] rate_code;
    logic              intr_en, pulse_en;
    logic [DATA_W-1:0] stat_byte;

    assign rate_code = r_q.rate[RATE_W-1:0];
    assign intr_en   = r_q.ctrl[CTRL_INTR_BIT];
    assign pulse_en  = r_q.ctrl[CTRL_PULSE_BIT];

    rtc_rate_decode u_dec (
        .code_i   (rate_code),
        .active_o (rate_active),
        .term_o   (rate_term)
    );

    rtc_period_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .restart_i  (restart),
        .tick_i     (tick_en),
        .term_i     (rate_term),
        .boundary_o (boundary)
    );

    always_comb begin
        restart = reg_wr && (reg_addr == ADR_RATE);
        wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
        rd_stat = reg_rd && (reg_addr == ADR_STAT);
        run     = rate_active && (intr_en || pulse_en);

        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (restart) r_d.rate = reg_wdata;
        if (wr_ctrl) r_d.ctrl = reg_wdata;
        if (rd_stat) r_d.flags = '0;
        // a new event takes precedence over the read-clear
        if (boundary && intr_en)  r_d.flags = '1;
        if (boundary && pulse_en) r_d.pulse = 1'b1;
    end

    always_comb begin
        stat_byte = '0;
        stat_byte[STAT_IRQ_BIT] = r_q.flags[1];
        stat_byte[STAT_PER_BIT] = r_q.flags[0];
        case (reg_addr)
            ADR_RATE: reg_rdata = r_q.rate;
            ADR_CTRL: reg_rdata = r_q.ctrl;
            ADR_STAT: reg_rdata = stat_byte;
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.rate  <= RATE_RST;
            r_q.ctrl  <= CTRL_RST;
            r_q.flags <= '0;
            r_q.pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_o       = r_q.flags[1];
    assign evt_pulse_o = r_q.pulse;
endmodule

// File: rtl/rtc_periodic_chk.sv
module rtc_periodic_chk
    import rtc_periodic_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              irq_o,
    input logic              evt_pulse_o,
    input logic [RATE_W-1:0] rate_code,
    input logic              pulse_en
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse_o |=> !evt_pulse_o); // R7

    AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse_o |-> $past(pulse_en)); // R7

    AST_IRQ_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tick_en)); // R6

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(irq_o && !(reg_rd && reg_addr == ADR_STAT)) |-> irq_o); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_addr == ADR_STAT && !tick_en) |-> !irq_o); // R8

    AST_ZERO_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rate_code == '0) |-> (!evt_pulse_o && !$rose(irq_o))); // R4
endmodule

bind rtc_periodic_gen rtc_periodic_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .reg_addr    (reg_addr),
    .reg_rd      (reg_rd),
    .irq_o       (irq_o),
    .evt_pulse_o (evt_pulse_o),
    .rate_code   (rate_code),
    .pulse_en    (pulse_en)
);

// File: tb/tb_rtc_periodic_gen.sv
module tb_rtc_periodic_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o, evt_pulse_o;

    int n_chk = 0;
    int n_fail = 0;
    int tick_div = 1;
    int ph = 0;
    int tick_cnt = 0;

    always #5 clk = ~clk;

    rtc_periodic_gen dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .evt_pulse_o(evt_pulse_o)
    );

    always @(negedge clk) begin
        tick_en = (ph == 0);
        ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
    end

    always @(posedge clk) if (tick_en) tick_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic meas_evt(output int ticks);
        int t0 = tick_cnt;
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!evt_pulse_o && guard < 40000);
        ticks = evt_pulse_o ? tick_cnt - t0 : -1;
    endtask

    task automatic meas_irq(output int ticks);
        int t0 = tick_cnt;
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!irq_o && guard < 40000);
        ticks = irq_o ? tick_cnt - t0 : -1;
    endtask

    function automatic int period_of(input int code);
        int eff = (code <= 2) ? code + 7 : code;
        return 1 << (eff - 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int t;
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); chk("R1 rate", d, 8'h26);
        rd(2'd1, d); chk("R1 ctrl", d, 8'h02);
        rd(2'd2, d); chk("R1 stat", d, 8'h00);
        chk("R1 irq", irq_o, 0);
        chk("R1 pulse", evt_pulse_o, 0);

        // R2 register access
        wr(2'd1, 8'h35); rd(2'd1, d); chk("R2 ctrl rw", d, 8'h35);
        wr(2'd0, 8'hA7); rd(2'd0, d); chk("R2 rate rw", d, 8'hA7);
        wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 stat ro", d, 8'h00);
        chk("R2 stat ro irq", irq_o, 0);
        rd(2'd3, d); chk("R2 addr3", d, 8'h00);

        // R3 sweep of every nonzero code, tick on every cycle
        wr(2'd1, 8'h48);
        for (int code = 1; code < 16; code++) begin
            wr(2'd0, 8'(8'h20 | code));
            meas_evt(t); chk($sformatf("R3 first code %0d", code), t, period_of(code));
            meas_evt(t); chk($sformatf("R3 second code %0d", code), t, period_of(code));
            chk("R6 irq set", irq_o, 1);
            rd(2'd2, d); chk("R6 stat flags", d, 8'hC0);
            chk("R8 irq cleared", irq_o, 0);
        end

        // R3 with a sparse timebase
        tick_div = 3;
        wr(2'd0, 8'h24);
        meas_evt(t); chk("R3 sparse code 4", t, 8);
        meas_evt(t); chk("R3 sparse code 4 again", t, 8);
        wr(2'd0, 8'h22);
        meas_evt(t); chk("R3 sparse alias code 2", t, 256);
        tick_div = 1;
        rd(2'd2, d);

        // R4 zero code
        wr(2'd0, 8'h20);
        rd(2'd2, d);
        seen = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (evt_pulse_o || irq_o) seen++;
        end
        chk("R4 no events", seen, 0);

        // R5 idle without enables, then full period from enable
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h23);
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (evt_pulse_o || irq_o) seen++;
        end
        chk("R5 idle", seen, 0);
        wr(2'd1, 8'h08);
        meas_evt(t); chk("R5 start period", t, 4);
        @(negedge clk); chk("R7 one cycle", evt_pulse_o, 0);
        rd(2'd2, d); chk("R7 no flags", d, 8'h00);
        chk("R7 no irq", irq_o, 0);

        // R6 interrupt path alone, exact edge
        wr(2'd1, 8'h40);
        wr(2'd0, 8'h23);
        seen = 0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk($sformatf("R6 irq at %0d", k), irq_o, (k == 4) ? 1 : 0);
            if (evt_pulse_o) seen++;
        end
        chk("R7 no pulse when disabled", seen, 0);

        // R9 collision: read one cycle before the next boundary
        repeat (3) @(negedge clk);
        reg_addr = 2'd2; reg_rd = 1'b1;
        #1 chk("R9 old value", reg_rdata, 8'hC0);
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R9 flags kept", irq_o, 1);
        rd(2'd2, d); chk("R8 read value", d, 8'hC0);
        chk("R8 clear after read", irq_o, 0);

        // R10 restart on rate write
        wr(2'd0, 8'h25);
        rd(2'd2, d);
        repeat (8) @(negedge clk);
        wr(2'd0, 8'h25);
        meas_irq(t); chk("R10 restart period", t, 16);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule